// File: doc/BRIEF.md
# Bit-Oriented Signaling Code Detector

This block sits on the receive side of a serial data link. It watches the link one bit at a time and picks out bit-oriented signaling codewords. Each codeword is two octets: a flag octet of all ones, then a code octet whose most and least significant bits are both zero. The link may also carry HDLC traffic. The block separates the codewords from that traffic and reports them through a message-type flag.

Bits come in on a valid/ready stream. A frame-boundary marker travels with the bits and sets the octet alignment that the search uses. A code counts as confirmed only after it has arrived a programmable number of times in a row with nothing between the repetitions. On confirmation the block stores the one-byte code and the repetition count, and it pulses end-of-message. On the first sighting of a code it pulses start-of-message. The stored values feed whatever logic the host uses to read them.

Back-pressure rule: `in_ready` is high at all times, so a bit is taken on every clock where `in_valid` is high. A source may drop `in_valid` for any number of cycles without effect.

Top module: `bos_code_detector`

## Requirements
- R1: `in_ready` is always 1. A bit is accepted on each rising edge where `in_valid` is 1. Cycles with `in_valid` at 0 change nothing, so gaps between bits do not alter any result.
- R2: An accepted bit with `in_frame_start` at 1 becomes the most significant bit of a new octet, and any partial octet is dropped. Octets are built from accepted bits, most significant bit first. Ones that straddle an octet boundary never form a flag.
- R3: A codeword is an octet equal to 0xFF followed at once by an octet with bit 7 = 0 and bit 0 = 0. That second octet is the code. A code octet with bit 7 or bit 0 set is not a codeword and produces no event.
- R4: `msg_type` is 1 after reset. On the first detection of a code, `sot_pulse` goes high and `msg_type` drops to 0 in the cycle after the code's last bit is accepted. `msg_type` then stays 0.
- R5: Each time the same code arrives again as the very next codeword, the repetition count rises by one. When the count reaches the threshold `rep_thresh`, the block does three things in the cycle after the last bit: it pulses `eot_pulse`, loads the code into `code_byte`, and loads the count into `rep_count`.
- R6: If a different valid code arrives before the threshold, counting restarts at 1 with a new `sot_pulse`. Any other octet where a flag or a repeat was expected clears the count and stores nothing.
- R7: A `rep_thresh` of 0 acts as 1. The first detection then raises `sot_pulse` and `eot_pulse` in the same cycle, with `rep_count` = 1.
- R8: `code_byte` and `rep_count` reset to 0. They change only in a cycle where `eot_pulse` is 1.
- R9: After a confirmation the count clears. The next codeword, even one with the same code, is a fresh first detection.
- R10: `sot_pulse` and `eot_pulse` are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Always 1: the block never stalls the stream |
| in_bit | input | 1 | Serial data-link bit |
| in_frame_start | input | 1 | Marks this bit as the first bit of a frame-aligned octet |
| rep_thresh | input | CNT_W | Repetitions needed to confirm a code (0 acts as 1) |
| msg_type | output | 1 | 0 once a bit-oriented code has been seen |
| sot_pulse | output | 1 | One-cycle start-of-message event |
| eot_pulse | output | 1 | One-cycle end-of-message (confirmation) event |
| code_byte | output | OCT_W | Last confirmed code |
| rep_count | output | CNT_W | Repetition count at the last confirmation |

## Verification
The hardest case to reach from the ports is a broken repetition run that restarts cleanly. The run must be cut at the exact octet where a repeat was due, and the cut may come from a rival code, from a stray octet, or from ones that only form a flag when the octets are misaligned. The stimulus builds octet-exact sequences of this kind. For example, two repeats of one code followed by three of another, or a codeword, a stray octet and then two codewords. It also sends a flag whose bits straddle an octet boundary before a frame marker realigns the stream. Some runs drop `in_valid` between bits. The scoreboard expects exactly one confirmation, with a known code and count, for each such sequence.

// File: rtl/bos_det_pkg.sv
package bos_det_pkg;
  // Tracker states: waiting for flag, flag seen with no run,
  // run active after a code, run active after a flag
  typedef enum logic [1:0] {
    TRK_IDLE     = 2'd0,
    TRK_FF_SEEN  = 2'd1,
    TRK_RUN_CODE = 2'd2,
    TRK_RUN_FF   = 2'd3
  } trk_state_e;
endpackage

// File: rtl/bos_octet_align.sv
module bos_octet_align #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             frame_mark,
  output logic             oct_vld,
  output logic [OCT_W-1:0] oct_val
);
  localparam int CW = $clog2(OCT_W);
  localparam logic [CW-1:0] LAST_POS = CW'(OCT_W - 1);

  logic [CW-1:0]    bit_cnt;
  logic [CW-1:0]    pos;
  logic [OCT_W-1:0] shreg;

  always_comb begin
    pos     = frame_mark ? '0 : bit_cnt;
    oct_vld = bit_vld && (pos == LAST_POS);
    oct_val = {shreg[OCT_W-2:0], bit_val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (bit_vld) begin
      shreg   <= {shreg[OCT_W-2:0], bit_val};
      bit_cnt <= (pos == LAST_POS) ? '0 : pos + CW'(1);
    end
  end

  // R2
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && frame_mark) |=> (bit_cnt == CW'(1)));
endmodule

// File: rtl/bos_code_track.sv
module bos_code_track
  import bos_det_pkg::*;
#(
  parameter int OCT_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oct_vld,
  input  logic [OCT_W-1:0] oct_val,
  input  logic [CNT_W-1:0] rep_thresh,
  output logic             msg_type,
  output logic             sot_pulse,
  output logic             eot_pulse,
  output logic [OCT_W-1:0] code_byte,
  output logic [CNT_W-1:0] rep_count
);
  trk_state_e       state, state_d;
  logic [CNT_W-1:0] run_cnt, cnt_d;
  logic [OCT_W-1:0] cand, cand_d;
  logic [CNT_W-1:0] eff_thr;
  logic [CNT_W:0]   next_cnt;
  logic             is_flag, is_code, first, again, sot_d, eot_d;

  always_comb begin
    is_flag  = &oct_val;
    is_code  = !oct_val[OCT_W-1] && !oct_val[0];
    eff_thr  = (rep_thresh == '0) ? CNT_W'(1) : rep_thresh;
    state_d  = state;
    cnt_d    = run_cnt;
    cand_d   = cand;
    sot_d    = 1'b0;
    eot_d    = 1'b0;
    first    = 1'b0;
    again    = 1'b0;
    if (oct_vld) begin
      unique case (state)
        TRK_IDLE: if (is_flag) state_d = TRK_FF_SEEN;
        TRK_FF_SEEN: begin
          if (is_code)       first   = 1'b1;
          else if (!is_flag) state_d = TRK_IDLE;
        end
        TRK_RUN_CODE: begin
          if (is_flag) state_d = TRK_RUN_FF;
          else begin
            state_d = TRK_IDLE;
            cnt_d   = '0;
          end
        end
        TRK_RUN_FF: begin
          if (is_code && oct_val == cand) again = 1'b1;
          else if (is_code)               first = 1'b1;
          else begin
            state_d = is_flag ? TRK_FF_SEEN : TRK_IDLE;
            cnt_d   = '0;
          end
        end
        default: state_d = TRK_IDLE;
      endcase
    end
    next_cnt = first ? (CNT_W+1)'(1) : ({1'b0, run_cnt} + (CNT_W+1)'(1));
    if (first || again) begin
      sot_d = first;
      if (first) cand_d = oct_val;
      if (next_cnt >= {1'b0, eff_thr}) begin
        eot_d   = 1'b1;
        state_d = TRK_IDLE;
        cnt_d   = '0;
      end else begin
        state_d = TRK_RUN_CODE;
        cnt_d   = next_cnt[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TRK_IDLE;
      run_cnt   <= '0;
      cand      <= '0;
      msg_type  <= 1'b1;
      sot_pulse <= 1'b0;
      eot_pulse <= 1'b0;
      code_byte <= '0;
      rep_count <= '0;
    end else begin
      state     <= state_d;
      run_cnt   <= cnt_d;
      cand      <= cand_d;
      sot_pulse <= sot_d;
      eot_pulse <= eot_d;
      if (sot_d) msg_type <= 1'b0;
      if (eot_d) begin
        code_byte <= first ? oct_val : cand;
        rep_count <= next_cnt[CNT_W-1:0];
      end
    end
  end

  // R3
  code_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> (!code_byte[OCT_W-1] && !code_byte[0]));
  // R4
  type_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_pulse || eot_pulse) |-> !msg_type);
  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eot_pulse |-> ($stable(code_byte) && $stable(rep_count)));
  // R5
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> (rep_count != '0));
  // R10
  sot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sot_pulse |=> !sot_pulse);
  // R10
  eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |=> !eot_pulse);
endmodule

// File: rtl/bos_code_detector.sv
module bos_code_detector #(
  parameter int OCT_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_frame_start,
  input  logic [CNT_W-1:0] rep_thresh,
  output logic             msg_type,
  output logic             sot_pulse,
  output logic             eot_pulse,
  output logic [OCT_W-1:0] code_byte,
  output logic [CNT_W-1:0] rep_count
);
  logic             take;
  logic             oct_vld;
  logic [OCT_W-1:0] oct_val;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  bos_octet_align #(.OCT_W(OCT_W)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (take),
    .bit_val    (in_bit),
    .frame_mark (in_frame_start),
    .oct_vld    (oct_vld),
    .oct_val    (oct_val)
  );

  bos_code_track #(.OCT_W(OCT_W), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .oct_vld    (oct_vld),
    .oct_val    (oct_val),
    .rep_thresh (rep_thresh),
    .msg_type   (msg_type),
    .sot_pulse  (sot_pulse),
    .eot_pulse  (eot_pulse),
    .code_byte  (code_byte),
    .rep_count  (rep_count)
  );

  // R1
  stall_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);
endmodule

// File: tb/test_bos_code_detector.sv
module test_bos_code_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic       in_frame_start = 1'b0;
  logic [7:0] rep_thresh = 8'd1;
  logic       msg_type, sot_pulse, eot_pulse;
  logic [7:0] code_byte, rep_count;

  always #5 clk = ~clk;

  bos_code_detector i_bos_code_detector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_frame_start(in_frame_start), .rep_thresh(rep_thresh),
    .msg_type(msg_type), .sot_pulse(sot_pulse), .eot_pulse(eot_pulse),
    .code_byte(code_byte), .rep_count(rep_count)
  );

  typedef struct {
    logic [7:0] code;
    int         cnt;
    string      req;
  } exp_t;

  exp_t expq[$];
  int vectors = 0, miscompares = 0;
  int sot_seen = 0, eot_seen = 0, both_seen = 0;
  int use_gaps = 0, gap_ctr = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n) begin
      if (sot_pulse) sot_seen++;
      if (eot_pulse) eot_seen++;
      if (sot_pulse && eot_pulse) both_seen++;
      if (eot_pulse) begin
        if (expq.size() == 0) begin
          check("R5 unexpected confirmation", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check({e.req, " code"}, int'(code_byte), int'(e.code));
          check({e.req, " count"}, int'(rep_count), e.cnt);
        end
      end
    end
  end

  task automatic send_bit(input logic b, input logic fs);
    if (use_gaps != 0) begin
      gap_ctr++;
      if (gap_ctr % 3 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_frame_start = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    in_frame_start = fs;
  endtask

  task automatic send_octet(input logic [7:0] o, input logic fs);
    for (int i = 7; i >= 0; i--) send_bit(o[i], fs && (i == 7));
  endtask

  task automatic send_cw(input logic [7:0] code, input logic fs);
    send_octet(8'hFF, fs);
    send_octet(code, 1'b0);
  endtask

  task automatic go_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_frame_start = 1'b0;
    end
  endtask

  task automatic push_exp(input logic [7:0] c, input int n, input string r);
    exp_t e;
    e.code = c; e.cnt = n; e.req = r;
    expq.push_back(e);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    check("watchdog timeout", 1, 0);
    finish_run();
  end

  initial begin
    int s0, e0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R8 reset code_byte", int'(code_byte), 0);
    check("R8 reset rep_count", int'(rep_count), 0);
    check("R4 reset msg_type", int'(msg_type), 1);
    check("R1 in_ready high", int'(in_ready), 1);
    check("R10 no events at reset", int'(sot_pulse | eot_pulse), 0);

    // R4/R5: threshold 3, one code repeated three times
    rep_thresh = 8'd3;
    s0 = sot_seen;
    push_exp(8'h46, 3, "R5");
    send_cw(8'h46, 1'b1);
    go_idle(1);
    check("R4 sot after first code", int'(sot_pulse), 1);
    check("R4 msg_type cleared", int'(msg_type), 0);
    go_idle(1);
    check("R10 sot one cycle", int'(sot_pulse), 0);
    send_cw(8'h46, 1'b0);
    send_cw(8'h46, 1'b0);
    go_idle(1);
    check("R5 eot in cycle after last bit", int'(eot_pulse), 1);
    go_idle(1);
    check("R10 eot one cycle", int'(eot_pulse), 0);
    check("R4 single sot for run", sot_seen - s0, 1);

    // R6 + R1: rival code restarts the run, bits with gaps
    use_gaps = 1;
    s0 = sot_seen;
    push_exp(8'h1C, 3, "R6");
    send_cw(8'h46, 1'b0);
    send_cw(8'h46, 1'b0);
    send_cw(8'h1C, 1'b0);
    send_cw(8'h1C, 1'b0);
    send_cw(8'h1C, 1'b0);
    go_idle(3);
    use_gaps = 0;
    check("R6 rival code raises new sot", sot_seen - s0, 2);

    // R6/R8: stray octet breaks the run, nothing stored
    rep_thresh = 8'd2;
    e0 = eot_seen;
    send_cw(8'h30, 1'b0);
    send_octet(8'h55, 1'b0);
    send_cw(8'h30, 1'b0);
    go_idle(3);
    check("R6 no confirm after break", eot_seen - e0, 0);
    check("R8 code_byte held", int'(code_byte), 8'h1C);
    check("R8 rep_count held", int'(rep_count), 3);
    push_exp(8'h30, 2, "R6 restart");
    send_cw(8'h30, 1'b0);
    go_idle(3);

    // R3: code octets with bit 7 or bit 0 set are ignored
    rep_thresh = 8'd1;
    s0 = sot_seen; e0 = eot_seen;
    send_cw(8'h43, 1'b0);
    send_cw(8'h81, 1'b0);
    send_cw(8'hC2, 1'b0);
    go_idle(3);
    check("R3 invalid code no sot", sot_seen - s0, 0);
    check("R3 invalid code no eot", eot_seen - e0, 0);

    // R7: threshold 0 acts as 1
    rep_thresh = 8'd0;
    b0 = both_seen;
    push_exp(8'h7C, 1, "R7");
    send_cw(8'h7C, 1'b0);
    go_idle(3);
    check("R7 sot and eot together", both_seen - b0, 1);

    // R9: four repeats with threshold 2 give two confirmations
    rep_thresh = 8'd2;
    s0 = sot_seen;
    push_exp(8'h2C, 2, "R9 first");
    push_exp(8'h2C, 2, "R9 second");
    use_gaps = 1;
    for (int k = 0; k < 4; k++) send_cw(8'h2C, 1'b0);
    use_gaps = 0;
    go_idle(3);
    check("R9 fresh detection after confirm", sot_seen - s0, 2);

    // R2: misaligned flag is not seen; frame marker realigns
    rep_thresh = 8'd1;
    e0 = eot_seen;
    for (int k = 0; k < 4; k++) send_bit(1'b0, 1'b0);
    send_cw(8'h52, 1'b0);
    go_idle(3);
    check("R2 misaligned codeword ignored", eot_seen - e0, 0);
    push_exp(8'h52, 1, "R2 realigned");
    send_cw(8'h52, 1'b1);
    go_idle(4);

    check("R5 all expected confirmations seen", expq.size(), 0);
    finish_run();
  end
endmodule